// File: doc/BRIEF.md
# Flash Program and Sector-Erase Sequencer

This block drives a parallel flash through a bank-switched CPU window without software help. A client hands it one request: an operation (program one byte, or erase one 4 KB sector), a bank number, a 14-bit offset inside the 16 KB window and a data byte. The engine then replays the whole unlock and command dialogue as single-clock bus cycles. The flash sees a bank-register write at `$C000` before every command write, because the command addresses land in different banks.

When the last command write has gone out, the engine reads the target location over and over. It declares success once two reads in a row return the value it expects: the data byte after a program, or `$FF` after an erase. If that never happens within a set number of reads, it reports a timeout. A request that names a bank beyond the last one, or an erase address that is not on a sector boundary, is refused at once and puts nothing on the bus.

Top module: `flash_seq_engine`

## Requirements
- R1: Every operation starts with the unlock prefix of four write cycles on consecutive clocks: `$01`→`$C000`, `$AA`→`$9555`, `$00`→`$C000`, `$55`→`$AAAA`. `busWrite` is 1 on each of them.
- R2: A program operation (`reqErase`=0) follows the prefix with `$01`→`$C000`, `$A0`→`$9555`, bank→`$C000`, then data→(`$8000` + offset). That is eight writes in all, and the first one comes on the clock after the accepting edge.
- R3: An erase operation (`reqErase`=1) follows the prefix with `$01`→`$C000`, `$80`→`$9555`, a second copy of the prefix, bank→`$C000`, then `$30`→(`$8000` + offset). That is twelve writes in all.
- R4: On the clock right after the last write, polling begins. Each poll is a one-clock read strobe (`busWrite`=0) at the target address. `busRdData` is sampled on the next clock, so two read strobes are never adjacent.
- R5: An operation succeeds only when two successive poll reads both equal the expected value: the data byte for a program, `$FF` for an erase. A matching read followed by a mismatch starts the count again.
- R6: A request whose bank exceeds `NUM_BANKS`-1, or an erase whose offset has any of bits 11:0 set, is rejected. `opDone` and `opReject` go high on the clock after the request, no bus cycle is issued and `busy` stays low.
- R7: If `MAX_POLLS` reads complete without success, the operation ends with `opDone` and `opTimeout`, and no further read is issued.
- R8: `busy` is high from the first write until the operation ends. A `reqValid` seen while busy is ignored and produces no bus cycle afterwards.
- R9: `opDone` is a one-clock pulse that comes two clocks after the final read strobe (or one clock after a rejected request). Exactly one of `opOk`, `opTimeout` and `opReject` is high with it.
- R10: After reset, `busy`, `busStrobe` and `opDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when idle |
| reqErase | input | 1 | 1 = sector erase, 0 = byte program |
| reqBank | input | 8 | Target bank number |
| reqOffset | input | 14 | Offset inside the 16 KB window |
| reqData | input | 8 | Byte to program |
| busStrobe | output | 1 | One-clock bus cycle strobe |
| busWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| busAddr | output | 16 | CPU-side address of the cycle |
| busWrData | output | 8 | Write data of the cycle |
| busRdData | input | 8 | Read data, valid the clock after a read strobe |
| busy | output | 1 | Operation in progress |
| opDone | output | 1 | End-of-operation pulse |
| opOk | output | 1 | Operation completed |
| opTimeout | output | 1 | Polling limit reached |
| opReject | output | 1 | Request refused |

## Verification
The bench builds the engine with `MAX_POLLS` = 6 and the default `NUM_BANKS` = 32. With that limit, running out of polls takes only a few dozen clocks, and the timeout case can sit next to the success cases in one short run. With 32 banks, bank `$1F` is the last one accepted and `$20` is the first one refused. The flash model returns scripted read patterns: a slow finish, a match broken by a mismatch, a late erase and a value that never settles. These exercise the two-in-a-row rule and the read limit.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int BANK_W   = 8;
  localparam int OFF_W    = 14;
  localparam int SECTOR_W = 12;

  localparam int PROG_STEPS  = 8;
  localparam int ERASE_STEPS = 12;
  localparam int STEP_W      = $clog2(ERASE_STEPS + 1);

  localparam logic [ADDR_W-1:0] BANK_REG_ADDR = 16'hC000;
  localparam logic [ADDR_W-1:0] KEY_ADDR_A    = 16'h9555;
  localparam logic [ADDR_W-1:0] KEY_ADDR_B    = 16'hAAAA;
  localparam logic [ADDR_W-1:0] WINDOW_BASE   = 16'h8000;

  localparam logic [DATA_W-1:0] KEY_BYTE_A  = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_BYTE_B  = 8'h55;
  localparam logic [DATA_W-1:0] OPC_PROGRAM = 8'hA0;
  localparam logic [DATA_W-1:0] OPC_SETUP   = 8'h80;
  localparam logic [DATA_W-1:0] OPC_SECTOR  = 8'h30;
  localparam logic [DATA_W-1:0] ERASED_BYTE = 8'hFF;
  localparam logic [DATA_W-1:0] BANK_ONE    = 8'h01;
  localparam logic [DATA_W-1:0] BANK_ZERO   = 8'h00;

  typedef logic [STEP_W-1:0] step_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WRITE,
    ST_POLL_RD,
    ST_POLL_CHK
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic stepAdv;
    logic pollIssue;
    logic pollSample;
    logic pollPhase;
  } seqCtl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic reqOk;
    logic lastStep;
    logic pollPass;
    logic pollLimit;
  } seqSts_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } busBeat_t;

  // one of the four writes of the unlock prefix
  function automatic busBeat_t unlockBeat(input logic [1:0] k);
    busBeat_t b;
    case (k)
      2'd0:    b = '{addr: BANK_REG_ADDR, data: BANK_ONE};
      2'd1:    b = '{addr: KEY_ADDR_A,    data: KEY_BYTE_A};
      2'd2:    b = '{addr: BANK_REG_ADDR, data: BANK_ZERO};
      default: b = '{addr: KEY_ADDR_B,    data: KEY_BYTE_B};
    endcase
    return b;
  endfunction

endpackage

// File: rtl/flash_seq_datapath.sv
module flash_seq_datapath
  import flash_seq_pkg::*;
#(
  parameter int MAX_POLLS = 1024,
  parameter int NUM_BANKS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              reqErase,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] busRdData,
  output seqSts_t           sts,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWrData
);

  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [POLL_W-1:0] POLL_MAX = POLL_W'(MAX_POLLS);
  localparam step_t LAST_PROG  = step_t'(PROG_STEPS - 1);
  localparam step_t LAST_ERASE = step_t'(ERASE_STEPS - 1);

  logic              opErase;
  logic [BANK_W-1:0] bankReg;
  logic [OFF_W-1:0]  offReg;
  logic [DATA_W-1:0] dataReg;
  step_t             stepIdx;
  logic [POLL_W-1:0] pollCnt;
  logic              prevMatch;

  logic [ADDR_W-1:0] targetAddr;
  logic [DATA_W-1:0] expectByte;
  logic              rdMatch;
  busBeat_t          beat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opErase   <= 1'b0;
      bankReg   <= '0;
      offReg    <= '0;
      dataReg   <= '0;
      stepIdx   <= '0;
      pollCnt   <= '0;
      prevMatch <= 1'b0;
    end else if (ctl.load) begin
      opErase   <= reqErase;
      bankReg   <= reqBank;
      offReg    <= reqOffset;
      dataReg   <= reqData;
      stepIdx   <= '0;
      pollCnt   <= '0;
      prevMatch <= 1'b0;
    end else begin
      if (ctl.stepAdv)    stepIdx   <= stepIdx + step_t'(1);
      if (ctl.pollIssue)  pollCnt   <= pollCnt + POLL_W'(1);
      if (ctl.pollSample) prevMatch <= rdMatch;
    end
  end

  assign targetAddr = WINDOW_BASE | {{(ADDR_W-OFF_W){1'b0}}, offReg};
  assign expectByte = opErase ? ERASED_BYTE : dataReg;
  assign rdMatch    = (busRdData == expectByte);

  // command script, indexed by step
  always_comb begin
    beat = unlockBeat(stepIdx[1:0]);
    case (stepIdx)
      step_t'(4):  beat = '{addr: BANK_REG_ADDR, data: BANK_ONE};
      step_t'(5):  beat = '{addr: KEY_ADDR_A, data: opErase ? OPC_SETUP : OPC_PROGRAM};
      step_t'(6):  beat = opErase ? unlockBeat(2'd0) : '{addr: BANK_REG_ADDR, data: bankReg};
      step_t'(7):  beat = opErase ? unlockBeat(2'd1) : '{addr: targetAddr, data: dataReg};
      step_t'(8):  beat = unlockBeat(2'd2);
      step_t'(9):  beat = unlockBeat(2'd3);
      step_t'(10): beat = '{addr: BANK_REG_ADDR, data: bankReg};
      step_t'(11): beat = '{addr: targetAddr, data: OPC_SECTOR};
      default:     ;
    endcase
  end

  assign busAddr   = ctl.pollPhase ? targetAddr : beat.addr;
  assign busWrData = ctl.pollPhase ? '0 : beat.data;

  assign sts.reqOk     = (int'(reqBank) < NUM_BANKS) &&
                         (!reqErase || (reqOffset[SECTOR_W-1:0] == '0));
  assign sts.lastStep  = (stepIdx == (opErase ? LAST_ERASE : LAST_PROG));
  assign sts.pollPass  = rdMatch && prevMatch;
  assign sts.pollLimit = (pollCnt >= POLL_MAX);

  // R7: never more reads than the limit
  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= POLL_MAX);

  // R2 / R3: the script index stays inside the script of the operation
  p_step_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    stepIdx <= (opErase ? step_t'(ERASE_STEPS) : step_t'(PROG_STEPS)));

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  seqSts_t sts,
  output seqCtl_t ctl,
  output logic    busStrobe,
  output logic    busWrite,
  output logic    busy,
  output logic    opDone,
  output logic    opOk,
  output logic    opTimeout,
  output logic    opReject
);

  seqState_e state;

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE:     ctl.load = reqValid;
      ST_WRITE:    ctl.stepAdv = 1'b1;
      ST_POLL_RD:  begin ctl.pollIssue = 1'b1;  ctl.pollPhase = 1'b1; end
      ST_POLL_CHK: begin ctl.pollSample = 1'b1; ctl.pollPhase = 1'b1; end
      default:     ;
    endcase
  end

  assign busStrobe = (state == ST_WRITE) || (state == ST_POLL_RD);
  assign busWrite  = (state == ST_WRITE);
  assign busy      = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      opDone    <= 1'b0;
      opOk      <= 1'b0;
      opTimeout <= 1'b0;
      opReject  <= 1'b0;
    end else begin
      opDone    <= 1'b0;
      opOk      <= 1'b0;
      opTimeout <= 1'b0;
      opReject  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (sts.reqOk) begin
              state <= ST_WRITE;
            end else begin
              opDone   <= 1'b1;
              opReject <= 1'b1;
            end
          end
        end
        ST_WRITE:   if (sts.lastStep) state <= ST_POLL_RD;
        ST_POLL_RD: state <= ST_POLL_CHK;
        ST_POLL_CHK: begin
          if (sts.pollPass) begin
            state  <= ST_IDLE;
            opDone <= 1'b1;
            opOk   <= 1'b1;
          end else if (sts.pollLimit) begin
            state     <= ST_IDLE;
            opDone    <= 1'b1;
            opTimeout <= 1'b1;
          end else begin
            state <= ST_POLL_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> $onehot({opOk, opTimeout, opReject}));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);

  p_read_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && !busWrite) |=> !busStrobe);

  p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opDone && opReject) |-> !$past(busStrobe));

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine
  import flash_seq_pkg::*;
#(
  parameter int MAX_POLLS = 1024,
  parameter int NUM_BANKS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqErase,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [OFF_W-1:0]    reqOffset,
  input  logic [DATA_W-1:0]   reqData,
  output logic                busStrobe,
  output logic                busWrite,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W-1:0]   busWrData,
  input  logic [DATA_W-1:0]   busRdData,
  output logic                busy,
  output logic                opDone,
  output logic                opOk,
  output logic                opTimeout,
  output logic                opReject
);

  seqCtl_t ctl;
  seqSts_t sts;

  flash_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .sts       (sts),
    .ctl       (ctl),
    .busStrobe (busStrobe),
    .busWrite  (busWrite),
    .busy      (busy),
    .opDone    (opDone),
    .opOk      (opOk),
    .opTimeout (opTimeout),
    .opReject  (opReject)
  );

  flash_seq_datapath #(
    .MAX_POLLS (MAX_POLLS),
    .NUM_BANKS (NUM_BANKS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqErase  (reqErase),
    .reqBank   (reqBank),
    .reqOffset (reqOffset),
    .reqData   (reqData),
    .busRdData (busRdData),
    .sts       (sts),
    .busAddr   (busAddr),
    .busWrData (busWrData)
  );

endmodule

// File: tb/flash_seq_engine_tb.sv
module flash_seq_engine_tb;

  localparam int TB_POLLS = 6;

  typedef struct {
    bit         wr;
    logic [15:0] addr;
    logic [7:0]  data;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqErase = 1'b0;
  logic [7:0]  reqBank = '0;
  logic [13:0] reqOffset = '0;
  logic [7:0]  reqData = '0;
  logic        busStrobe, busWrite, busy, opDone, opOk, opTimeout, opReject;
  logic [15:0] busAddr;
  logic [7:0]  busWrData;
  logic [7:0]  busRdData = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int lastRdCyc = -10;
  int firstRdCyc = -1;
  int reqCyc = 0;
  int doneCyc = 0;
  bit finished = 0;

  item_t      expQ[$];
  logic [7:0] respQ[$];
  logic [7:0] finalVal = 8'h00;

  always #10 clk = ~clk;

  flash_seq_engine #(.MAX_POLLS(TB_POLLS), .NUM_BANKS(32)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqErase(reqErase),
    .reqBank(reqBank), .reqOffset(reqOffset), .reqData(reqData),
    .busStrobe(busStrobe), .busWrite(busWrite), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .busy(busy),
    .opDone(opDone), .opOk(opOk), .opTimeout(opTimeout), .opReject(opReject)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pushW(input logic [15:0] a, input logic [7:0] d);
    expQ.push_back('{wr: 1'b1, addr: a, data: d});
  endtask

  task automatic pushR(input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) expQ.push_back('{wr: 1'b0, addr: a, data: 8'h00});
  endtask

  task automatic pushUnlock();
    pushW(16'hC000, 8'h01); pushW(16'h9555, 8'hAA);
    pushW(16'hC000, 8'h00); pushW(16'hAAAA, 8'h55);
  endtask

  // expected bus script for a program (R1, R2)
  task automatic expectProgram(input logic [7:0] b, input logic [13:0] o,
                               input logic [7:0] d, input int reads);
    pushUnlock();
    pushW(16'hC000, 8'h01); pushW(16'h9555, 8'hA0);
    pushW(16'hC000, b);     pushW(16'h8000 | {2'b00, o}, d);
    pushR(16'h8000 | {2'b00, o}, reads);
  endtask

  // expected bus script for an erase (R1, R3)
  task automatic expectErase(input logic [7:0] b, input logic [13:0] o, input int reads);
    pushUnlock();
    pushW(16'hC000, 8'h01); pushW(16'h9555, 8'h80);
    pushUnlock();
    pushW(16'hC000, b);     pushW(16'h8000 | {2'b00, o}, 8'h30);
    pushR(16'h8000 | {2'b00, o}, reads);
  endtask

  task automatic request(input bit e, input logic [7:0] b, input logic [13:0] o,
                         input logic [7:0] d);
    @(negedge clk); #1;
    reqErase = e; reqBank = b; reqOffset = o; reqData = d; reqValid = 1'b1;
    reqCyc = cyc; firstRdCyc = -1;
    @(negedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    bit seen = 0;
    if (opDone) begin seen = 1; doneCyc = cyc; end
    for (int i = 0; i < 400 && !seen; i++) begin
      @(negedge clk); #1;
      if (opDone) begin seen = 1; doneCyc = cyc; end
    end
    chk(seen, "R9", "opDone never seen", 0, 1);
  endtask

  // scoreboard monitor and flash responder
  always @(negedge clk) begin
    cyc++;
    if (rstN && busStrobe) begin
      if (!busWrite) begin
        busRdData <= (respQ.size() > 0) ? respQ.pop_front() : finalVal;
        chk(lastRdCyc != cyc - 1, "R4", "adjacent read strobes", cyc, lastRdCyc + 2);
        lastRdCyc = cyc;
        if (firstRdCyc < 0) firstRdCyc = cyc;
      end
      if (expQ.size() == 0) begin
        chk(0, "R8", "unexpected bus cycle addr", busAddr, 0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        chk(busWrite == e.wr, e.wr ? "R1" : "R4", "cycle direction", busWrite, e.wr);
        chk(busAddr == e.addr, "R2", "cycle address", busAddr, e.addr);
        if (e.wr) chk(busWrData == e.data, "R3", "write data", busWrData, e.data);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !busStrobe && !opDone, "R10", "outputs in reset",
        {busy, busStrobe, opDone}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(!busy && !busStrobe && !opDone, "R10", "outputs after reset",
        {busy, busStrobe, opDone}, 0);

    // program, slow finish: 2 busy reads then data twice
    respQ = '{8'hDA, 8'hDA}; finalVal = 8'h5A;
    expectProgram(8'h05, 14'h1234, 8'h5A, 4);
    request(0, 8'h05, 14'h1234, 8'h5A);
    chk(busy, "R8", "busy during program", busy, 1);
    waitDone();
    chk(opOk && !opTimeout && !opReject, "R5", "program ok flags",
        {opOk, opTimeout, opReject}, 3'b100);
    chk(firstRdCyc == reqCyc + 9, "R4", "first poll after 8 writes", firstRdCyc, reqCyc + 9);
    chk(doneCyc == lastRdCyc + 2, "R9", "done timing", doneCyc, lastRdCyc + 2);
    chk(expQ.size() == 0, "R2", "program items left", expQ.size(), 0);
    @(negedge clk); #1;
    chk(!opDone && !busy, "R9", "done is one pulse", {opDone, busy}, 0);

    // erase, last bank, highest sector, one non-erased read
    respQ = '{8'h00}; finalVal = 8'hFF;
    expectErase(8'h1F, 14'h3000, 3);
    request(1, 8'h1F, 14'h3000, 8'h00);
    waitDone();
    chk(opOk, "R3", "erase ok", opOk, 1);
    chk(firstRdCyc == reqCyc + 13, "R3", "first poll after 12 writes", firstRdCyc, reqCyc + 13);
    chk(expQ.size() == 0, "R3", "erase items left", expQ.size(), 0);

    // match broken by mismatch restarts the pair count
    respQ = '{8'h77, 8'h00, 8'h77}; finalVal = 8'h77;
    expectProgram(8'h00, 14'h3FFF, 8'h77, 4);
    request(0, 8'h00, 14'h3FFF, 8'h77);
    waitDone();
    chk(opOk, "R5", "match-miss-match needs 4 reads", opOk, 1);
    chk(expQ.size() == 0, "R5", "reads left", expQ.size(), 0);

    // unaligned erase rejected
    request(1, 8'h02, 14'h1800, 8'h00);
    chk(opDone && opReject && !opOk, "R6", "unaligned erase rejected",
        {opDone, opReject, opOk}, 3'b110);
    chk(cyc == reqCyc + 1 && !busy, "R6", "reject timing and idle", cyc, reqCyc + 1);

    // bank above range rejected
    request(0, 8'h20, 14'h0000, 8'h12);
    chk(opDone && opReject, "R6", "bank 0x20 rejected", {opDone, opReject}, 3'b11);
    repeat (4) @(negedge clk);

    // timeout: value never settles
    respQ = '{}; finalVal = 8'h00;
    expectProgram(8'h03, 14'h0100, 8'h11, TB_POLLS);
    request(0, 8'h03, 14'h0100, 8'h11);
    waitDone();
    chk(opTimeout && !opOk, "R7", "timeout flag", {opTimeout, opOk}, 2'b10);
    chk(expQ.size() == 0, "R7", "read count at limit", expQ.size(), 0);

    // request while busy is ignored
    respQ = '{}; finalVal = 8'hC3;
    expectProgram(8'h07, 14'h0042, 8'hC3, 2);
    request(0, 8'h07, 14'h0042, 8'hC3);
    @(negedge clk); #1;
    reqErase = 1; reqBank = 8'h01; reqOffset = 14'h0000; reqValid = 1'b1;
    @(negedge clk); #1;
    reqValid = 1'b0;
    chk(busy, "R8", "busy held mid-sequence", busy, 1);
    waitDone();
    chk(opOk, "R8", "first op completes", opOk, 1);
    repeat (20) @(negedge clk);
    #1;
    chk(expQ.size() == 0 && !busy, "R8", "no cycles from ignored request",
        expQ.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule